// File: doc/BRIEF.md
# Two-Word Instruction Skip Sequencer

This block is the fetch and decode stage of a small processor with 16-bit instruction words. Most instructions occupy one word. Four of them occupy two: a register-to-register move, a long call, a long jump and a pointer load. The sequencer recognises the opening word of such a pair and holds it. When the next word arrives, it joins that word's 12-bit operand field to the held opening word and issues one decoded instruction.

The block also handles conditional skips. When a test-and-skip word is accepted together with a true condition from the datapath, the next accepted word is squashed. Every trailing word of a pair carries 1111 in its top four bits. When such a word appears with no opening word pending, it becomes a NOP. A skip that lands in the middle of a pair therefore discards the opening word, and the orphaned trailing word then falls out as a NOP. No instruction-length lookahead is needed.

All outputs are registered. Results appear in the cycle after the fetched word is accepted.

Top module: `twoword_decode_seq`

## Requirements
- R1: While the asynchronous reset is held, and after it is released, out_valid, out_nop and pc_adv read 0 and no pair is pending. A trailing word (top bits 1111) accepted first after reset yields out_nop.
- R2: An accepted word opens a pair when its top bits match one of these patterns: 1100 (move, op code 1), 1110110 (call, op 2), 11101111 (jump, op 3), or 11101110 followed by 00 (pointer load, op 4). Such a word issues nothing: the next cycle has out_valid=0 and out_nop=0.
- R3: The word accepted after an opening word is consumed as its operand. In the next cycle, out_valid=1, out_op equals the pair's op code, out_first holds the opening word and out_ext holds the consumed word's low 12 bits.
- R4: For a call or jump, out_target equals the opening word's low 8 bits joined above the trailing word's low 12 bits, giving 20 bits.
- R5: A word whose top four bits are 1111, accepted with no pair pending, yields out_nop=1 and out_valid=0.
- R6: A skip word 0110011x issues with op code 5, with out_first equal to the word and out_ext equal to 0. If skip_cond is 1 when the skip word is accepted, the next accepted word, even after idle cycles, is squashed: it gives out_nop=1 and out_valid=0.
- R7: Exactly one word is squashed. A squashed opening word starts no pair, so its trailing word becomes a NOP. A squashed skip word arms no further squash.
- R8: skip_cond has no effect unless the accepted word is an unsquashed skip word.
- R9: Any other word issues alone with op code 6, with out_first equal to the word and out_ext equal to 0. Op code 0 means nothing was issued.
- R10: pc_adv is 1 exactly in the cycle after an accepted word. Cycles with fetch_valid=0 leave the pairing and squash state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Word on fetch_word is accepted this cycle |
| fetch_word | input | 16 | Fetched program word |
| skip_cond | input | 1 | Datapath says the tested register is zero |
| out_valid | output | 1 | A decoded instruction is issued |
| out_op | output | 3 | Issued op code (0 none, 1 move, 2 call, 3 jump, 4 pointer load, 5 skip, 6 single) |
| out_first | output | 16 | Opening or single instruction word |
| out_ext | output | 12 | Operand taken from the trailing word |
| out_target | output | 20 | Combined call/jump target |
| out_nop | output | 1 | A NOP is inserted for a squashed or stray word |
| pc_adv | output | 1 | Program counter advances by one word |

## Verification
The bench sends a skip taken into the opening word of a pair. A design that squashed two words, or that looked ahead at instruction length, would lose or issue the trailing word wrongly where a NOP belongs. It checks that the squash survives idle fetch cycles and that a squashed skip arms nothing, either of which a careless squash bit would get wrong. It also feeds a pointer-load lookalike with the wrong sub-field and a non-skip word with skip_cond raised. A loose decoder would open a pair for the first, and a leaky condition path would squash a good instruction after the second.

// File: rtl/twseq_pkg.sv
package twseq_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_MOVE   = 3'd1,
    OP_CALL   = 3'd2,
    OP_GOTO   = 3'd3,
    OP_LDPTR  = 3'd4,
    OP_SKIPZ  = 3'd5,
    OP_SINGLE = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    W_SINGLE = 2'd0,
    W_FIRST  = 2'd1,
    W_SECOND = 2'd2,
    W_SKIP   = 2'd3
  } wclass_e;
endpackage

// File: rtl/twseq_classify.sv
module twseq_classify
  import twseq_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int HI_W  = 10
) (
  input  logic [HI_W-1:0] hi_bits,
  output wclass_e         cls,
  output op_e             op
);
  logic [TAG_W-1:0] tag;
  logic [7:0]       top8;
  logic [1:0]       sub2;

  assign tag  = hi_bits[HI_W-1 -: TAG_W];
  assign top8 = hi_bits[HI_W-1 -: 8];
  assign sub2 = hi_bits[HI_W-9 -: 2];

  always_comb begin
    cls = W_SINGLE;
    op  = OP_SINGLE;
    if (tag == '1) begin
      cls = W_SECOND;
      op  = OP_NONE;
    end else if (top8[7:4] == 4'b1100) begin
      cls = W_FIRST;
      op  = OP_MOVE;
    end else if (top8[7:1] == 7'b1110110) begin
      cls = W_FIRST;
      op  = OP_CALL;
    end else if (top8 == 8'b11101111) begin
      cls = W_FIRST;
      op  = OP_GOTO;
    end else if (top8 == 8'b11101110 && sub2 == 2'b00) begin
      cls = W_FIRST;
      op  = OP_LDPTR;
    end else if (top8[7:1] == 7'b0110011) begin
      cls = W_SKIP;
      op  = OP_SKIPZ;
    end
  end
endmodule

// File: rtl/twseq_pair_ctl.sv
module twseq_pair_ctl
  import twseq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OPND_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  input  wclass_e           cls,
  input  op_e               op,
  input  logic              skip_cond,
  output logic              issue,
  output logic              nop_now,
  output op_e               issue_op,
  output logic [WORD_W-1:0] issue_first,
  output logic [OPND_W-1:0] issue_ext,
  output logic              pend,
  output logic              squash
);
  logic              pend_q, pend_d;
  logic              sq_q, sq_d;
  logic [WORD_W-1:0] held_q, held_d;
  op_e               hop_q, hop_d;

  always_comb begin
    pend_d      = pend_q;
    sq_d        = sq_q;
    held_d      = held_q;
    hop_d       = hop_q;
    issue       = 1'b0;
    nop_now     = 1'b0;
    issue_op    = OP_NONE;
    issue_first = word;
    issue_ext   = '0;
    if (accept) begin
      if (sq_q) begin
        nop_now = 1'b1;
        sq_d    = 1'b0;
      end else if (pend_q) begin
        issue       = 1'b1;
        issue_op    = hop_q;
        issue_first = held_q;
        issue_ext   = word[OPND_W-1:0];
        pend_d      = 1'b0;
      end else begin
        case (cls)
          W_SECOND: nop_now = 1'b1;
          W_FIRST: begin
            pend_d = 1'b1;
            held_d = word;
            hop_d  = op;
          end
          W_SKIP: begin
            issue    = 1'b1;
            issue_op = op;
            sq_d     = skip_cond;
          end
          default: begin
            issue    = 1'b1;
            issue_op = op;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sq_q   <= 1'b0;
      held_q <= '0;
      hop_q  <= OP_NONE;
    end else if (accept) begin
      pend_q <= pend_d;
      sq_q   <= sq_d;
      held_q <= held_d;
      hop_q  <= hop_d;
    end
  end

  assign pend   = pend_q;
  assign squash = sq_q;

  // R3: a consumed trailing word closes the pair
  p_pend_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && accept && !sq_q) |=> !pend_q);

  // R7: a squash lasts for one accepted word only
  p_squash_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_q && accept) |=> !sq_q);

  // R10: idle cycles hold the sequencing state
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(pend_q) && $stable(sq_q)));

  // R7: pending pair and squash never coexist
  p_excl_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && sq_q));
endmodule

// File: rtl/twseq_issue_reg.sv
module twseq_issue_reg
  import twseq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OPND_W = 12,
  parameter int PAGE_W = 8,
  localparam int TGT_W = PAGE_W + OPND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              issue,
  input  logic              nop_now,
  input  op_e               issue_op,
  input  logic [WORD_W-1:0] issue_first,
  input  logic [OPND_W-1:0] issue_ext,
  output logic              out_valid,
  output logic              out_nop,
  output logic              pc_adv,
  output logic [2:0]        out_op,
  output logic [WORD_W-1:0] out_first,
  output logic [OPND_W-1:0] out_ext,
  output logic [TGT_W-1:0]  out_target
);
  logic              vld_q, nop_q, pc_q;
  op_e               op_q;
  logic [WORD_W-1:0] first_q;
  logic [OPND_W-1:0] ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      nop_q <= 1'b0;
      pc_q  <= 1'b0;
      op_q  <= OP_NONE;
    end else begin
      vld_q <= issue;
      nop_q <= nop_now;
      pc_q  <= accept;
      op_q  <= issue ? issue_op : OP_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      ext_q   <= '0;
    end else if (issue) begin
      first_q <= issue_first;
      ext_q   <= issue_ext;
    end
  end

  assign out_valid  = vld_q;
  assign out_nop    = nop_q;
  assign pc_adv     = pc_q;
  assign out_op     = op_q;
  assign out_first  = first_q;
  assign out_ext    = ext_q;
  assign out_target = {first_q[PAGE_W-1:0], ext_q};

  // R5: an inserted NOP is never also an issued instruction
  p_nop_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_nop));

  // R10: every issue or NOP comes from a word that advanced the PC
  p_issue_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_nop) |-> pc_adv);
endmodule

// File: rtl/twoword_decode_seq.sv
module twoword_decode_seq
  import twseq_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int TAG_W       = 4,
  parameter int PAGE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int OPND_W     = WORD_W - TAG_W,
  localparam int HI_W       = 10,
  localparam int TGT_W      = PAGE_W + OPND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              skip_cond,
  output logic              out_valid,
  output logic [2:0]        out_op,
  output logic [WORD_W-1:0] out_first,
  output logic [OPND_W-1:0] out_ext,
  output logic [TGT_W-1:0]  out_target,
  output logic              out_nop,
  output logic              pc_adv
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= 1'b1;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  logic              accept;
  wclass_e           cls;
  op_e               cls_op;
  logic              issue, nop_now, pend, squash;
  op_e               issue_op;
  logic [WORD_W-1:0] issue_first;
  logic [OPND_W-1:0] issue_ext;

  assign accept = fetch_valid;

  twseq_classify #(.TAG_W(TAG_W), .HI_W(HI_W)) u_cls (
    .hi_bits (fetch_word[WORD_W-1 -: HI_W]),
    .cls     (cls),
    .op      (cls_op)
  );

  twseq_pair_ctl #(.WORD_W(WORD_W), .OPND_W(OPND_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .accept      (accept),
    .word        (fetch_word),
    .cls         (cls),
    .op          (cls_op),
    .skip_cond   (skip_cond),
    .issue       (issue),
    .nop_now     (nop_now),
    .issue_op    (issue_op),
    .issue_first (issue_first),
    .issue_ext   (issue_ext),
    .pend        (pend),
    .squash      (squash)
  );

  twseq_issue_reg #(.WORD_W(WORD_W), .OPND_W(OPND_W), .PAGE_W(PAGE_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .accept      (accept),
    .issue       (issue),
    .nop_now     (nop_now),
    .issue_op    (issue_op),
    .issue_first (issue_first),
    .issue_ext   (issue_ext),
    .out_valid   (out_valid),
    .out_nop     (out_nop),
    .pc_adv      (pc_adv),
    .out_op      (out_op),
    .out_first   (out_first),
    .out_ext     (out_ext),
    .out_target  (out_target)
  );

  // R3: a word arriving while a pair is open issues a two-word op
  p_pair_issue_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend && fetch_valid && !squash) |=>
      (out_valid && out_op >= 3'd1 && out_op <= 3'd4));

  // R2: an opening word issues nothing by itself
  p_first_silent_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_valid && !pend && !squash && cls == W_FIRST) |=>
      (!out_valid && !out_nop));

  // R6: a squashed word comes out as a NOP
  p_squash_nop_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (squash && fetch_valid) |=> (out_nop && !out_valid));
endmodule

// File: tb/twoword_decode_seq_test.sv
module twoword_decode_seq_test;
  logic        clk;
  logic        rst_n;
  logic        fetch_valid;
  logic [15:0] fetch_word;
  logic        skip_cond;
  logic        out_valid;
  logic [2:0]  out_op;
  logic [15:0] out_first;
  logic [11:0] out_ext;
  logic [19:0] out_target;
  logic        out_nop;
  logic        pc_adv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit        v;
    bit        n;
    bit        p;
    bit [2:0]  op;
    bit [15:0] first;
    bit [11:0] ext;
    bit [19:0] tgt;
    string     tag;
  } exp_t;

  exp_t q[$];

  bit        m_pend;
  bit        m_sq;
  bit [15:0] m_first;
  bit [2:0]  m_op;

  twoword_decode_seq uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .skip_cond(skip_cond), .out_valid(out_valid), .out_op(out_op),
    .out_first(out_first), .out_ext(out_ext), .out_target(out_target),
    .out_nop(out_nop), .pc_adv(pc_adv)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // op code for an opening word per R2, 0 when the word opens no pair
  function automatic bit [2:0] pair_op(input bit [15:0] w);
    if (w[15:12] == 4'b1100) return 3'd1;
    if (w[15:9] == 7'b1110110) return 3'd2;
    if (w[15:8] == 8'b11101111) return 3'd3;
    if (w[15:8] == 8'b11101110 && w[7:6] == 2'b00) return 3'd4;
    return 3'd0;
  endfunction

  task automatic drive(input bit v, input bit [15:0] w, input bit cond, input string tag);
    exp_t e;
    @(negedge clk);
    fetch_valid = v;
    fetch_word  = w;
    skip_cond   = cond;
    e.v = 0; e.n = 0; e.p = v; e.op = 0; e.first = 0; e.ext = 0; e.tgt = 0; e.tag = tag;
    if (v) begin
      if (m_sq) begin
        e.n = 1; m_sq = 0;
      end else if (m_pend) begin
        e.v = 1; e.op = m_op; e.first = m_first; e.ext = w[11:0];
        e.tgt = {m_first[7:0], w[11:0]}; m_pend = 0;
      end else if (w[15:12] == 4'hF) begin
        e.n = 1;
      end else if (pair_op(w) != 0) begin
        m_pend = 1; m_first = w; m_op = pair_op(w);
      end else if (w[15:9] == 7'b0110011) begin
        e.v = 1; e.op = 3'd5; e.first = w; m_sq = cond;
      end else begin
        e.v = 1; e.op = 3'd6; e.first = w;
      end
    end
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    bit bad;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        bad = (out_valid !== e.v) || (out_nop !== e.n) || (pc_adv !== e.p);
        if (e.v && (out_op !== e.op || out_first !== e.first || out_ext !== e.ext)) bad = 1;
        if (e.v && (e.op == 3'd2 || e.op == 3'd3) && out_target !== e.tgt) bad = 1;
        if (bad) begin
          errors++;
          $display("FAIL %s: got v=%b n=%b p=%b op=%0d first=%h ext=%h tgt=%h; expected v=%b n=%b p=%b op=%0d first=%h ext=%h tgt=%h",
                   e.tag, out_valid, out_nop, pc_adv, out_op, out_first, out_ext, out_target,
                   e.v, e.n, e.p, e.op, e.first, e.ext, e.tgt);
        end
      end
    end
  end

  task automatic check_idle_outputs(input string tag);
    checks++;
    if (out_valid !== 1'b0 || out_nop !== 1'b0 || pc_adv !== 1'b0) begin
      errors++;
      $display("FAIL %s: got v=%b n=%b p=%b expected 0 0 0", tag, out_valid, out_nop, pc_adv);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    m_pend = 0; m_sq = 0; m_first = 0; m_op = 0;
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_word = '0; skip_cond = 1'b0;
    repeat (3) @(negedge clk);
    check_idle_outputs("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check_idle_outputs("R1 after release");

    drive(1, 16'hF123, 0, "R1 R5 stray after reset");
    drive(1, 16'h2400, 0, "R9 single");
    drive(1, 16'hC123, 0, "R2 move first");
    drive(1, 16'hF456, 0, "R3 move pair");
    drive(1, 16'hED5A, 0, "R2 call first");
    drive(1, 16'hF789, 0, "R4 call target");
    drive(1, 16'hEF12, 0, "R2 jump first");
    drive(1, 16'hF345, 0, "R4 jump target");
    drive(1, 16'hEE12, 0, "R2 ptr first");
    drive(1, 16'hF0AB, 0, "R3 ptr pair");
    drive(1, 16'hEEC0, 0, "R2 ptr lookalike single");
    drive(1, 16'hF001, 0, "R5 stray after lookalike");
    drive(1, 16'h6600, 1, "R6 skip taken");
    drive(1, 16'hC111, 0, "R7 squashed opener");
    drive(1, 16'hF222, 0, "R7 orphan trailer nop");
    drive(1, 16'h2401, 0, "R7 resumes");
    drive(1, 16'h6700, 0, "R8 skip not taken");
    drive(1, 16'hC001, 0, "R8 opener unaffected");
    drive(1, 16'hF002, 0, "R8 pair unaffected");
    drive(1, 16'h2402, 1, "R8 cond on single");
    drive(1, 16'h2403, 0, "R8 not squashed");
    drive(1, 16'hC0AA, 0, "R10 opener");
    drive(0, 16'hF999, 0, "R10 idle");
    drive(0, 16'h0000, 1, "R10 idle");
    drive(1, 16'hF0BB, 0, "R10 pair across gap");
    drive(1, 16'h6601, 1, "R6 skip taken");
    drive(0, 16'h2404, 0, "R6 idle");
    drive(1, 16'h2405, 0, "R6 squash after gap");
    drive(1, 16'h6602, 1, "R6 skip taken");
    drive(1, 16'h6603, 1, "R7 squashed skip");
    drive(1, 16'h2406, 0, "R7 no second squash");
    drive(0, 16'h0000, 0, "R10 idle end");
    drive(0, 16'h0000, 0, "R10 idle end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule